// File: doc/BRIEF.md
# Key-Protected Clock Control Register

This block is a register-bus slave that holds the chip's clock-control settings: an enable for each of the two oscillators (low-speed and high-speed), a select bit that picks the CPU clock source, and a 2-bit divider code. Stray software writes must not be able to upset the clock tree, so the control register is guarded by a separate protection register. Before each update, software writes a fixed 8-bit key (8'b1001_0110) into the protection register. That key permits exactly one write to the control register. Any write to the control address clears the protection register to zero, whether or not the write was accepted.

Reads are never blocked. Both registers read back through a registered read port, and software can check the protection register to learn whether the next control write will be accepted. A standby-mode input tells the block when the CPU is halted or asleep. Neither mode changes the stored settings. The low-speed oscillator keeps running in both modes. During sleep with the low-speed source selected, the high-speed oscillator enable output is dropped, because nothing uses that clock.

Top module: `pwr_ctl_guard`

## Requirements
- R1: After reset the protection register reads 0x00, read data is 0x00, and the control register holds low-speed enable 1, high-speed enable 1, clock select 0 (high-speed) and divider code 00. This is control image 0x03.
- R2: A write to the control address while the protection register holds 8'h96 loads the control register from write data in the same clock edge. The bit fields are: bit 0 low-speed enable, bit 1 high-speed enable, bit 2 clock select (1 = low-speed source), bits 4:3 divider code. Bits 7:5 are discarded.
- R3: A write to the control address while the protection register holds any value other than 8'h96 leaves the control register unchanged.
- R4: Every write to the control address, accepted or not, clears the protection register to 0x00. A second control write without a fresh key is therefore ignored.
- R5: A write to the protection register stores its data as given. A value other than 8'h96 leaves the control register locked.
- R6: A read of the control address returns the control image (bits 7:5 zero) on rdata_o one cycle after the read strobe, whatever the protection state.
- R7: A read of the protection address returns the stored protection value one cycle after the read strobe.
- R8: Halt mode (mode code 2'b01) changes no output.
- R9: In sleep mode (mode code 2'b10), the low-speed enable, clock select and divider outputs keep their stored values. The high-speed enable output is 0 when the clock select is 1, and otherwise follows its stored bit. Codes 2'b00 and 2'b11 act as run mode.
- R10: A read of any other address returns 0x00, and a write to any other address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 8 | Register address (control 0x00, protection 0x10) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data, held between reads |
| mode_i | input | 2 | Standby mode: 00 run, 01 halt, 10 sleep, 11 run |
| osc_lo_en_o | output | 1 | Low-speed oscillator enable |
| osc_hi_en_o | output | 1 | High-speed oscillator enable |
| clk_sel_o | output | 1 | CPU clock source, 1 = low-speed |
| div_code_o | output | 2 | CPU clock divider code |

## Verification
Register writes take effect at the strobe's clock edge. The control outputs follow that same edge and also respond combinationally to mode_i. Read data appears one edge after the read strobe and carries the register contents from before any write at that same edge. The bench drives inputs and samples at falling edges. It advances its reference model once per rising edge and compares every output at the next falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 2;

  typedef struct packed {
    logic [DIV_W-1:0] div_code;
    logic             clk_sel;
    logic             osc_hi_en;
    logic             osc_lo_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam ctrl_t CTRL_RST = '{div_code: '0, clk_sel: 1'b0,
                                 osc_hi_en: 1'b1, osc_lo_en: 1'b1};

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_HALT  = 2'b01,
    MODE_SLEEP = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;
endpackage

// File: rtl/pwrctl_decode.sv
module pwrctl_decode #(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h10
) (
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ctrl_wr_o,
  output logic              key_wr_o,
  output logic              ctrl_hit_o,
  output logic              key_hit_o,
  output logic              rd_o
);
  assign ctrl_hit_o = (addr_i == CTRL_ADDR);
  assign key_hit_o  = (addr_i == KEY_ADDR);
  assign ctrl_wr_o  = wr_en_i & ctrl_hit_o;
  assign key_wr_o   = wr_en_i & key_hit_o;
  assign rd_o       = rd_en_i;

  always_comb begin
    assert (!(ctrl_wr_o && key_wr_o)) else $error("p_one_target_r10");
  end
endmodule

// File: rtl/pwrctl_key_guard.sv
module pwrctl_key_guard
  import pwrctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY = 8'b1001_0110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic              ctrl_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] key_q_o,
  output logic              unlock_o
);
  logic [DATA_W-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        key_q <= '0;
    else if (ctrl_wr_i) key_q <= '0;  // any control write re-arms the lock
    else if (key_wr_i)  key_q <= wdata_i;
  end

  assign key_q_o  = key_q;
  assign unlock_o = (key_q == KEY);

  p_key_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> (key_q_o == '0));
  p_key_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr_i && !ctrl_wr_i |=> (key_q_o == $past(wdata_i)));
  p_key_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_wr_i && !ctrl_wr_i |=> $stable(key_q_o));
endmodule

// File: rtl/pwrctl_ctrl_reg.sv
module pwrctl_ctrl_reg
  import pwrctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              unlock_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic [1:0]        mode_i,
  output ctrl_t             ctrl_q_o,
  output logic              osc_lo_en_o,
  output logic              osc_hi_en_o,
  output logic              clk_sel_o,
  output logic [DIV_W-1:0]  div_code_o
);
  ctrl_t ctrl_q;
  logic  sleep;
  logic  hi_gate;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ctrl_q <= CTRL_RST;
    else if (ctrl_wr_i && unlock_i) ctrl_q <= ctrl_t'(wdata_i);
  end

  assign sleep   = (mode_e'(mode_i) == MODE_SLEEP);
  // sleeping on the low-speed clock: high-speed source has no consumer
  assign hi_gate = sleep & ctrl_q.clk_sel;

  assign ctrl_q_o    = ctrl_q;
  assign osc_lo_en_o = ctrl_q.osc_lo_en;
  assign osc_hi_en_o = ctrl_q.osc_hi_en & ~hi_gate;
  assign clk_sel_o   = ctrl_q.clk_sel;
  assign div_code_o  = ctrl_q.div_code;

  p_locked_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && !unlock_i |=> $stable(ctrl_q_o));
  p_unlock_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && unlock_i |=> (ctrl_q_o == $past(wdata_i)));
  p_sleep_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep && !ctrl_wr_i |=> $stable(osc_lo_en_o) && $stable(clk_sel_o) && $stable(div_code_o));
  p_no_write_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr_i |=> $stable(ctrl_q_o));
endmodule

// File: rtl/pwr_ctl_guard.sv
module pwr_ctl_guard
  import pwrctl_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h10,
  parameter logic [DATA_W-1:0] KEY       = 8'b1001_0110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [1:0]        mode_i,
  output logic              osc_lo_en_o,
  output logic              osc_hi_en_o,
  output logic              clk_sel_o,
  output logic [1:0]        div_code_o
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic              ctrl_wr, key_wr, ctrl_hit, key_hit, rd;
  logic              unlock;
  logic [DATA_W-1:0] key_q;
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] ctrl_img;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  pwrctl_decode #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .KEY_ADDR(KEY_ADDR)) u_dec (
    .wr_en_i, .rd_en_i, .addr_i,
    .ctrl_wr_o(ctrl_wr), .key_wr_o(key_wr),
    .ctrl_hit_o(ctrl_hit), .key_hit_o(key_hit), .rd_o(rd)
  );

  pwrctl_key_guard #(.KEY(KEY)) u_key (
    .clk_i, .rst_ni,
    .key_wr_i(key_wr), .ctrl_wr_i(ctrl_wr), .wdata_i(wdata_i),
    .key_q_o(key_q), .unlock_o(unlock)
  );

  pwrctl_ctrl_reg u_ctrl (
    .clk_i, .rst_ni,
    .ctrl_wr_i(ctrl_wr), .unlock_i(unlock), .wdata_i(wdata_i[CTRL_W-1:0]),
    .mode_i, .ctrl_q_o(ctrl_q),
    .osc_lo_en_o, .osc_hi_en_o, .clk_sel_o, .div_code_o
  );

  assign ctrl_img = {{PAD_W{1'b0}}, ctrl_q};

  always_comb begin
    rd_mux = '0;
    if (ctrl_hit)     rd_mux = ctrl_img;
    else if (key_hit) rd_mux = key_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  p_ctrl_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (addr_i == CTRL_ADDR) |=> (rdata_o == $past(ctrl_img)));
  p_key_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (addr_i == KEY_ADDR) |=> (rdata_o == $past(key_q)));
  p_rd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/tb_pwr_ctl_guard.sv
`timescale 1ns/1ps
module tb_pwr_ctl_guard;
  localparam logic [7:0] CA  = 8'h00;
  localparam logic [7:0] KA  = 8'h10;
  localparam logic [7:0] KEY = 8'h96;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic [1:0] mode_i = 2'b00;
  logic [7:0] rdata_o;
  logic       osc_lo_en_o, osc_hi_en_o, clk_sel_o;
  logic [1:0] div_code_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_key, m_ctrl, m_rd;

  always #5 clk = ~clk;

  pwr_ctl_guard dut (
    .clk_i(clk), .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .mode_i, .osc_lo_en_o, .osc_hi_en_o, .clk_sel_o, .div_code_o
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic exp_hi;
    exp_hi = m_ctrl[1] & ~((mode_i == 2'b10) & m_ctrl[2]);
    cmp(tag, "rdata", rdata_o, m_rd);
    cmp(tag, "lo_en", osc_lo_en_o, m_ctrl[0]);
    cmp(tag, "hi_en", osc_hi_en_o, exp_hi);
    cmp(tag, "clk_sel", clk_sel_o, m_ctrl[2]);
    cmp(tag, "div", div_code_o, m_ctrl[4:3]);
  endtask

  // one bus cycle: drive at falling edge, model at rising, compare at next fall
  task automatic step(input string tag, input bit wr, input bit rd,
                      input logic [7:0] a, input logic [7:0] d, input logic [1:0] md);
    wr_en_i = wr; rd_en_i = rd; addr_i = a; wdata_i = d; mode_i = md;
    @(posedge clk);
    if (rd) m_rd = (a == CA) ? m_ctrl : (a == KA) ? m_key : 8'h00;
    if (wr && a == CA) begin
      if (m_key == KEY) m_ctrl = d & 8'h1f;
      m_key = 8'h00;
    end else if (wr && a == KA) begin
      m_key = d;
    end
    @(negedge clk);
    wr_en_i = 0; rd_en_i = 0;
    check_all(tag);
  endtask

  initial begin
    m_key = 8'h00; m_ctrl = 8'h03; m_rd = 8'h00;
    #12;
    check_all("R1");
    @(negedge clk); rst_ni = 1'b1;
    step("R1", 0, 1, KA, 0, 2'b00);            // key reads 0
    step("R1", 0, 1, CA, 0, 2'b00);            // ctrl reads 0x03
    // locked write
    step("R3", 1, 0, CA, 8'h1c, 2'b00);
    step("R3", 0, 1, CA, 0, 2'b00);
    // wrong key
    step("R5", 1, 0, KA, 8'h69, 2'b00);
    step("R5", 0, 1, KA, 0, 2'b00);
    step("R5", 1, 0, CA, 8'h1c, 2'b00);
    step("R4", 0, 1, KA, 0, 2'b00);            // cleared after failed write
    // correct key, one-shot
    step("R7", 1, 0, KA, KEY, 2'b00);
    step("R7", 0, 1, KA, 0, 2'b00);
    step("R6", 0, 1, CA, 0, 2'b00);            // read while unlocked
    step("R2", 1, 0, CA, 8'hfe, 2'b00);        // upper bits dropped
    step("R4", 0, 1, KA, 0, 2'b00);
    step("R4", 1, 0, CA, 8'h01, 2'b00);        // no fresh key: ignored
    step("R6", 0, 1, CA, 0, 2'b00);
    // read and write in same cycle returns old value
    step("R2", 1, 0, KA, KEY, 2'b00);
    step("R6", 1, 1, CA, 8'h0b, 2'b00);
    step("R6", 0, 1, CA, 0, 2'b00);
    // standby modes
    step("R8", 0, 0, CA, 0, 2'b01);
    step("R8", 0, 0, CA, 0, 2'b01);
    step("R9", 0, 0, CA, 0, 2'b10);            // sel=0: hi stays
    step("R2", 1, 0, KA, KEY, 2'b00);
    step("R2", 1, 0, CA, 8'h17, 2'b00);        // sel=1, hi=1, lo=1, div=2
    step("R9", 0, 0, CA, 0, 2'b10);            // hi dropped
    step("R9", 0, 0, CA, 0, 2'b10);
    step("R9", 0, 0, CA, 0, 2'b11);            // reserved acts as run
    step("R8", 0, 0, CA, 0, 2'b01);
    step("R9", 0, 0, CA, 0, 2'b00);
    // unmapped address
    step("R10", 1, 0, 8'h44, KEY, 2'b00);
    step("R10", 0, 1, 8'h44, 0, 2'b00);
    step("R10", 0, 1, KA, 0, 2'b00);
    step("R10", 1, 0, 8'h01, 8'h00, 2'b00);
    step("R10", 0, 1, CA, 0, 2'b00);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule